// File: doc/BRIEF.md
# Conversion Command Queue Sequencer

This block steps through a small table of conversion commands and drives the timing of an analog-to-digital converter. Each command names an input channel, a final sample length, an amplifier bypass option and a pause option. After a trigger the sequencer runs the commands in table order. For each command it raises three phase levels in turn: an initial sample, a final sample and a resolution phase. Each phase lasts a set number of QCLK enable pulses. At the end of the resolution phase the converter's result is written out, tagged with the index of the command that produced it.

A command with its pause option set splits the table into subqueues. The sequencer halts after that command's result and waits for another trigger. That trigger resumes the walk at the next command. A queue ends at a command whose channel is the end code 63, or after the last table entry. A trigger that arrives while a conversion is in progress is dropped and raises a sticky overrun flag.

Top module: `adcq_sequencer`

## Requirements
- R1: After synchronous reset the outputs are as follows: busy, paused, done, overrun, res_we and all three phase levels are 0, and cur_idx is 0.
- R2: A command word written through the table port has this layout: channel in bits 5:0, final sample select (IST) in bits 7:6, bypass in bit 8 and pause in bit 9. While a command's phases run, adc_chan shows its channel.
- R3: With bypass 0, a command spends 2 QCLK enable pulses in the initial sample phase and 2, 4, 8 or 16 pulses in the final sample phase for IST = 0, 1, 2 or 3. It then spends 10 pulses in the resolution phase.
- R4: With bypass 1, the initial sample phase is skipped. The final sample lasts the larger of 4 and the length that IST selects, so the lengths are 4, 4, 8 or 16.
- R5: On the cycle after the last resolution pulse, res_we is high for one cycle. At that cycle res_idx is the command's table index and res_data is the adc_result value seen at that last pulse.
- R6: A trigger while idle starts the walk at entry 0. Commands with pause 0 are followed directly by the next entry, so each executed entry gives exactly one result, in index order.
- R7: After the result of a command with pause 1 that is not the last entry, paused is 1, busy is 0 and cur_idx is the index of the next entry. The next trigger resumes execution at that entry.
- R8: A command with channel 63 ends the queue without a conversion or a result. So does the result of the last entry, and that end takes precedence over its pause bit. Once the queue ends, done is 1, busy and paused are 0, and cur_idx holds the index of the ending entry. A later trigger clears done and restarts at entry 0.
- R9: A trigger while busy has no effect on the running queue and sets overrun. Overrun stays set until a trigger is accepted in the idle or paused state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| qclk_en | input | 1 | Converter time-base enable, one pulse per QCLK |
| trig | input | 1 | Trigger event, one cycle per event |
| ccw_we | input | 1 | Command table write strobe |
| ccw_waddr | input | IDX_W | Command table write index |
| ccw_wdata | input | 10 | Command word (pause, bypass, IST, channel) |
| adc_result | input | RES_W | Converter result |
| adc_chan | output | 6 | Channel of the current command |
| ph_init | output | 1 | Initial sample phase active |
| ph_final | output | 1 | Final sample phase active |
| ph_resolve | output | 1 | Resolution phase active |
| res_we | output | 1 | Result write strobe |
| res_idx | output | IDX_W | Result table index |
| res_data | output | RES_W | Result value |
| busy | output | 1 | A command is being executed |
| paused | output | 1 | Halted between subqueues |
| done | output | 1 | Queue completed |
| overrun | output | 1 | Trigger dropped while busy |
| cur_idx | output | IDX_W | Index of the current or next command |

## Verification
The assertions assume that the command table is not rewritten while a queue is running. They also assume that trig and qclk_en are single-cycle strobes sampled at the clock edge. Under those assumptions, the rule that a bypassed command never shows an initial phase and always samples at least four pulses holds. The bench writes the table only when busy is low. It drives triggers and the QCLK enable a few nanoseconds after the clock edge, with the enable either always high or pseudo-randomly thinned. The only trigger it sends during a run is a deliberate one, placed a few cycles into the first command.

// File: rtl/adcq_pkg.sv
package adcq_pkg;

    localparam int CHAN_W = 6;
    localparam int IST_W  = 2;
    localparam int CCW_W  = 10;
    localparam int CNT_W  = 5;

    localparam logic [CHAN_W-1:0] END_CHAN = 6'd63;

    typedef struct packed {
        logic              pause;
        logic              bypass;
        logic [IST_W-1:0]  ist;
        logic [CHAN_W-1:0] chan;
    } ccw_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PAUSE,
        S_LOAD,
        S_INIT,
        S_FINAL,
        S_RESOLVE
    } seq_state_e;

    // Final sample length in QCLK pulses; bypass raises it to a floor.
    function automatic logic [CNT_W-1:0] final_qclks(
        input logic [IST_W-1:0] ist,
        input logic             bypass,
        input int               byp_min
    );
        logic [CNT_W-1:0] len;
        len = CNT_W'(2) << ist;
        if (bypass && (len < CNT_W'(byp_min)))
            len = CNT_W'(byp_min);
        return len;
    endfunction

endpackage

// File: rtl/adcq_ccw_table.sv
module adcq_ccw_table
    import adcq_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  ccw_t             wdata,
    input  logic [IDX_W-1:0] rd_idx,
    output ccw_t             rd_word
);

    ccw_t mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < ENTRIES; e++)
                mem[e] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rd_word = mem[rd_idx];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(waddr)] == $past(wdata)));   // R2

endmodule

// File: rtl/adcq_phase_timer.sv
module adcq_phase_timer
    import adcq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             qclk_en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (qclk_en && (cnt != '0))
            cnt <= cnt - CNT_W'(1);
    end

    assign expire = qclk_en && (cnt == CNT_W'(1));

    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_val != '0));   // R3

endmodule

// File: rtl/adcq_queue_ctrl.sv
module adcq_queue_ctrl
    import adcq_pkg::*;
#(
    parameter int ENTRIES   = 16,
    parameter int RES_W     = 10,
    parameter int INIT_Q    = 2,
    parameter int RESOLVE_Q = 10,
    parameter int BYP_MIN_Q = 4,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic             expire,
    input  ccw_t             ccw,
    input  logic [RES_W-1:0] adc_result,
    output logic [IDX_W-1:0] idx,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             busy,
    output logic             paused,
    output logic             done,
    output logic             overrun,
    output logic             ph_init,
    output logic             ph_final,
    output logic             ph_resolve,
    output logic             res_we,
    output logic [IDX_W-1:0] res_idx,
    output logic [RES_W-1:0] res_data
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    seq_state_e state;

    assign busy       = (state == S_LOAD) || (state == S_INIT) ||
                        (state == S_FINAL) || (state == S_RESOLVE);
    assign paused     = (state == S_PAUSE);
    assign ph_init    = (state == S_INIT);
    assign ph_final   = (state == S_FINAL);
    assign ph_resolve = (state == S_RESOLVE);

    // Phase length loads for the shared timer
    always_comb begin
        load     = 1'b0;
        load_val = '0;
        case (state)
            S_LOAD: begin
                if (ccw.chan != END_CHAN) begin
                    load     = 1'b1;
                    load_val = ccw.bypass ? final_qclks(ccw.ist, 1'b1, BYP_MIN_Q)
                                          : CNT_W'(INIT_Q);
                end
            end
            S_INIT: begin
                if (expire) begin
                    load     = 1'b1;
                    load_val = final_qclks(ccw.ist, ccw.bypass, BYP_MIN_Q);
                end
            end
            S_FINAL: begin
                if (expire) begin
                    load     = 1'b1;
                    load_val = CNT_W'(RESOLVE_Q);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            idx      <= '0;
            done     <= 1'b0;
            overrun  <= 1'b0;
            res_we   <= 1'b0;
            res_idx  <= '0;
            res_data <= '0;
        end else begin
            res_we <= 1'b0;
            case (state)
                S_IDLE, S_PAUSE: begin
                    if (trig) begin
                        overrun <= 1'b0;
                        done    <= 1'b0;
                        state   <= S_LOAD;
                        if (state == S_IDLE)
                            idx <= '0;
                    end
                end
                S_LOAD: begin
                    if (ccw.chan == END_CHAN) begin
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end else begin
                        state <= ccw.bypass ? S_FINAL : S_INIT;
                    end
                end
                S_INIT: begin
                    if (expire)
                        state <= S_FINAL;
                end
                S_FINAL: begin
                    if (expire)
                        state <= S_RESOLVE;
                end
                S_RESOLVE: begin
                    if (expire) begin
                        res_we   <= 1'b1;
                        res_idx  <= idx;
                        res_data <= adc_result;
                        if (idx == LAST_IDX) begin
                            done  <= 1'b1;
                            state <= S_IDLE;
                        end else begin
                            idx   <= idx + IDX_W'(1);
                            state <= ccw.pause ? S_PAUSE : S_LOAD;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
            if (trig && busy)
                overrun <= 1'b1;
        end
    end

    AST_BYP_SKIPS_INIT: assert property (@(posedge clk) disable iff (rst)
        ph_init |-> !ccw.bypass);   // R4

    AST_RES_AFTER_RESOLVE: assert property (@(posedge clk) disable iff (rst)
        res_we |-> $past(ph_resolve));   // R5

    AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (paused && !trig) |=> (paused && $stable(idx)));   // R7

    AST_DONE_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !paused));   // R8

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
        (trig && busy) |=> overrun);   // R9

    AST_TRIG_KEEPS_INDEX: assert property (@(posedge clk) disable iff (rst)
        (trig && busy && !expire) |=> $stable(idx));   // R9

endmodule

// File: rtl/adcq_sequencer.sv
module adcq_sequencer
    import adcq_pkg::*;
#(
    parameter int ENTRIES   = 16,
    parameter int RES_W     = 10,
    parameter int INIT_Q    = 2,
    parameter int RESOLVE_Q = 10,
    parameter int BYP_MIN_Q = 4,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             qclk_en,
    input  logic             trig,
    input  logic             ccw_we,
    input  logic [IDX_W-1:0] ccw_waddr,
    input  logic [9:0]       ccw_wdata,
    input  logic [RES_W-1:0] adc_result,
    output logic [5:0]       adc_chan,
    output logic             ph_init,
    output logic             ph_final,
    output logic             ph_resolve,
    output logic             res_we,
    output logic [IDX_W-1:0] res_idx,
    output logic [RES_W-1:0] res_data,
    output logic             busy,
    output logic             paused,
    output logic             done,
    output logic             overrun,
    output logic [IDX_W-1:0] cur_idx
);

    ccw_t             cur_ccw;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expire;

    adcq_ccw_table #(.ENTRIES(ENTRIES)) i_table (
        .clk     (clk),
        .rst     (rst),
        .we      (ccw_we),
        .waddr   (ccw_waddr),
        .wdata   (ccw_t'(ccw_wdata)),
        .rd_idx  (cur_idx),
        .rd_word (cur_ccw)
    );

    adcq_phase_timer i_timer (
        .clk      (clk),
        .rst      (rst),
        .qclk_en  (qclk_en),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    adcq_queue_ctrl #(
        .ENTRIES   (ENTRIES),
        .RES_W     (RES_W),
        .INIT_Q    (INIT_Q),
        .RESOLVE_Q (RESOLVE_Q),
        .BYP_MIN_Q (BYP_MIN_Q)
    ) i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .trig       (trig),
        .expire     (tmr_expire),
        .ccw        (cur_ccw),
        .adc_result (adc_result),
        .idx        (cur_idx),
        .load       (tmr_load),
        .load_val   (tmr_val),
        .busy       (busy),
        .paused     (paused),
        .done       (done),
        .overrun    (overrun),
        .ph_init    (ph_init),
        .ph_final   (ph_final),
        .ph_resolve (ph_resolve),
        .res_we     (res_we),
        .res_idx    (res_idx),
        .res_data   (res_data)
    );

    assign adc_chan = cur_ccw.chan;

    // Independent count of final-sample pulses for the bypass floor check
    logic [CNT_W:0] fin_seen;

    always_ff @(posedge clk) begin
        if (rst)
            fin_seen <= '0;
        else if (ph_final)
            fin_seen <= fin_seen + (CNT_W+1)'(qclk_en);
        else
            fin_seen <= '0;
    end

    AST_BYP_FINAL_MIN: assert property (@(posedge clk) disable iff (rst)
        ($fell(ph_final) && $past(cur_ccw.bypass)) |-> (fin_seen >= (CNT_W+1)'(BYP_MIN_Q)));   // R4

endmodule

// File: tb/test_adcq_sequencer.sv
module test_adcq_sequencer;

    localparam int ENTRIES = 16;
    localparam int IDX_W   = 4;
    localparam int RES_W   = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             qclk_en = 1'b0;
    logic             trig = 1'b0;
    logic             ccw_we = 1'b0;
    logic [IDX_W-1:0] ccw_waddr = '0;
    logic [9:0]       ccw_wdata = '0;
    logic [RES_W-1:0] adc_result;
    logic [5:0]       adc_chan;
    logic             ph_init, ph_final, ph_resolve;
    logic             res_we;
    logic [IDX_W-1:0] res_idx;
    logic [RES_W-1:0] res_data;
    logic             busy, paused, done, overrun;
    logic [IDX_W-1:0] cur_idx;

    adcq_sequencer i_adcq_sequencer (
        .clk(clk), .rst(rst), .qclk_en(qclk_en), .trig(trig),
        .ccw_we(ccw_we), .ccw_waddr(ccw_waddr), .ccw_wdata(ccw_wdata),
        .adc_result(adc_result), .adc_chan(adc_chan),
        .ph_init(ph_init), .ph_final(ph_final), .ph_resolve(ph_resolve),
        .res_we(res_we), .res_idx(res_idx), .res_data(res_data),
        .busy(busy), .paused(paused), .done(done), .overrun(overrun),
        .cur_idx(cur_idx)
    );

    always #5 clk = ~clk;

    // Converter model: result derived from the selected channel
    assign adc_result = {4'h0, adc_chan} ^ 10'h2A5;

    int n_tests = 0;
    int n_fail  = 0;
    int qmode   = 0;
    int exp_idx = 0;
    int nwr     = 0;
    int model_idx = 0;
    bit model_paused = 0;
    int ci = 0, cf = 0, cr = 0;
    logic [5:0] last_chan = '0;
    logic [9:0] shadow [ENTRIES];

    task automatic check(input string req, input int act, input int exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_final(input logic [1:0] ist, input logic byp);
        int len;
        len = 2 << ist;
        if (byp && len < 4) len = 4;
        return len;
    endfunction

    function automatic int exp_res(input logic [5:0] ch);
        return int'({4'h0, ch} ^ 10'h2A5);
    endfunction

    function automatic logic [9:0] mk(input int ch, input int ist, input bit byp, input bit pse);
        return {pse, byp, 2'(ist), 6'(ch)};
    endfunction

    // QCLK enable generator
    initial begin
        forever begin
            @(posedge clk);
            #2;
            qclk_en = (qmode == 0) ? 1'b1 : ($urandom_range(0, 2) == 0);
        end
    end

    // Monitor: counts phase pulses and checks each result write
    always @(negedge clk) begin
        if (!rst) begin
            if (qclk_en) begin
                if (ph_init)    ci++;
                if (ph_final)   cf++;
                if (ph_resolve) cr++;
            end
            if (ph_resolve) last_chan = adc_chan;
            if (res_we) begin
                logic [9:0] w;
                w = shadow[exp_idx];
                check("R6", int'(res_idx), exp_idx, "result index order");
                check("R5", int'(res_data), exp_res(w[5:0]), "result data");
                check("R2", int'(last_chan), int'(w[5:0]), "channel shown during phases");
                if (w[8]) begin
                    check("R4", ci, 0, "bypass initial pulses");
                    check("R4", cf, exp_final(w[7:6], 1'b1), "bypass final pulses");
                end else begin
                    check("R3", ci, 2, "initial pulses");
                    check("R3", cf, exp_final(w[7:6], 1'b0), "final pulses");
                end
                check("R3", cr, 10, "resolution pulses");
                ci = 0; cf = 0; cr = 0;
                nwr++;
                exp_idx++;
            end
        end
    end

    task automatic wr_ccw(input int a, input logic [9:0] w);
        @(posedge clk);
        #2;
        ccw_we = 1'b1; ccw_waddr = IDX_W'(a); ccw_wdata = w;
        @(posedge clk);
        #2;
        ccw_we = 1'b0;
        shadow[a] = w;
    endtask

    task automatic pulse_trig();
        @(posedge clk);
        #2 trig = 1'b1;
        @(posedge clk);
        #2 trig = 1'b0;
    endtask

    task automatic run_seg(input bit from_pause, input bit inject);
        int i, start, nexp, endi;
        bit ex_pause;
        start = from_pause ? model_idx : 0;
        i = start; nexp = 0; ex_pause = 0; endi = 0;
        forever begin
            if (shadow[i][5:0] == 6'd63) begin endi = i; break; end
            nexp++;
            if (i == ENTRIES - 1) begin endi = i; break; end
            if (shadow[i][9]) begin endi = i + 1; ex_pause = 1; break; end
            i++;
        end
        exp_idx = start; nwr = 0;
        ci = 0; cf = 0; cr = 0;
        pulse_trig();
        if (inject) begin
            repeat (5) @(posedge clk);
            #2 trig = 1'b1;
            @(posedge clk);
            #2 trig = 1'b0;
        end
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
        check("R6", nwr, nexp, "results in segment");
        check("R8", int'(done), ex_pause ? 0 : 1, "done flag");
        check("R7", int'(paused), ex_pause ? 1 : 0, "paused flag");
        check(ex_pause ? "R7" : "R8", int'(cur_idx), endi, "cur_idx at stop");
        check("R9", int'(overrun), inject ? 1 : 0, "overrun flag");
        model_idx = endi;
        model_paused = ex_pause;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < ENTRIES; k++) shadow[k] = '0;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", int'(busy), 0, "busy after reset");
        check("R1", int'(paused), 0, "paused after reset");
        check("R1", int'(done), 0, "done after reset");
        check("R1", int'(overrun), 0, "overrun after reset");
        check("R1", int'(cur_idx), 0, "cur_idx after reset");
        check("R1", int'({ph_init, ph_final, ph_resolve, res_we}), 0, "phases after reset");

        // Directed table: every IST, both bypass values, a pause, an end code
        wr_ccw(0, mk(5, 0, 0, 0));
        wr_ccw(1, mk(17, 3, 0, 0));
        wr_ccw(2, mk(33, 0, 1, 0));
        wr_ccw(3, mk(2, 3, 1, 0));
        wr_ccw(4, mk(40, 1, 1, 1));
        wr_ccw(5, mk(9, 2, 0, 0));
        wr_ccw(6, mk(63, 0, 0, 0));
        run_seg(0, 0);            // R7 pause after entry 4
        run_seg(1, 0);            // R7 resume, R8 end code at 6
        run_seg(0, 1);            // R9 overrun during run, R8 restart from 0
        run_seg(1, 0);            // R9 overrun cleared by accepted trigger

        // R8 end code in entry 0: no conversion
        wr_ccw(0, mk(63, 2, 1, 1));
        run_seg(0, 0);

        // R8 full table, pause on last entry gives completion
        qmode = 1;
        for (int k = 0; k < ENTRIES; k++)
            wr_ccw(k, mk(k, k % 4, k[0], k == ENTRIES - 1));
        run_seg(0, 0);

        // Random tables
        for (int t = 0; t < 20; t++) begin
            for (int k = 0; k < ENTRIES; k++) begin
                int ch;
                ch = ($urandom_range(0, 9) == 0) ? 63 : int'($urandom_range(0, 62));
                wr_ccw(k, mk(ch, int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                             $urandom_range(0, 4) == 0));
            end
            run_seg(0, 0);
            while (model_paused) run_seg(1, 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule